// File: doc/BRIEF.md
# Multithreaded Commit Thread Selector

This block decides, for one commit slot, which hardware thread is allowed to retire the instruction at the head of its reorder buffer. Each cycle it looks at the per-thread pipeline state, whether each thread's reorder buffer is empty, whether each head entry is ready, and the sequence number held at each head. From these it returns a valid flag and a thread index. The surrounding retire logic uses that answer and pulses a consume input when it actually spends the slot on the chosen thread.

Three selection policies can be chosen at run time. A fair rotating policy keeps a priority order of threads in registers and sends a thread to the back of that order each time its pick is consumed. An oldest-first policy compares head sequence numbers and picks the globally oldest eligible head. A greedy policy uses the same oldest-first choice and is meant to be called several times per cycle by the retire logic. When the block is built for a single thread, that thread is picked from its state alone.

Top module: `commit_thread_sel`

## Requirements
- R1: Thread state codes are idle=0, running=1, squashing=2, trap pending=3, fetch-fault pending=4. Policy codes are greedy=0, rotating=1, oldest=2, reserved=3. After reset the rotating priority order is ascending thread index (0 first).
- R2: Under the rotating policy the selector picks the first thread in the priority order whose state is idle or running and whose head-ready bit is set. The ROB-empty input is not considered.
- R3: When consume_i is high, the rotating policy is selected and valid_o is high, the chosen thread moves to the back of the priority order on the next clock edge. The other threads keep their relative order.
- R4: The priority order does not change in a cycle where consume_i is low, the policy is not rotating, or valid_o is low.
- R5: Under the oldest policy a thread is eligible when its ROB is not empty, its head is ready and its state is idle, running or fetch-fault pending. Of the eligible threads, the one whose head sequence number (unsigned) is smallest is picked.
- R6: Under the oldest and greedy policies, equal smallest sequence numbers resolve to the lowest thread index.
- R7: The greedy policy gives the same selection as the oldest policy.
- R8: When no thread is eligible, valid_o is 0 and tid_o is 0.
- R9: The reserved policy code gives valid_o=0 and tid_o=0.
- R10: With NUM_THREADS=1, thread 0 is picked whenever its state is idle, running or fetch-fault pending, whatever the policy, head-ready and ROB-empty inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| policy_i | input | 2 | Selection policy code |
| state_i | input | 3*NUM_THREADS | Per-thread state code, thread t at bits [3t+2:3t] |
| rob_empty_i | input | NUM_THREADS | Per-thread ROB empty |
| head_ready_i | input | NUM_THREADS | Per-thread head entry ready to commit |
| head_seq_i | input | SEQ_W*NUM_THREADS | Per-thread head sequence number |
| consume_i | input | 1 | Retire logic spent this slot on the current selection |
| valid_o | output | 1 | A thread was selected |
| tid_o | output | TID_W | Selected thread index |

## Verification
The hardest case to reach is a rotating-policy selection made deep in a priority order that has already been reshuffled by many earlier consumes. In that case a wrong move-to-back shows up only several picks later. The stimulus first drives runs of consumed picks with every thread eligible. It then switches to random state, readiness and consume patterns, so that the order drifts away from ascending. Head sequence numbers are drawn from a small range, which makes ties under the oldest policy frequent.

// File: rtl/cts_pkg.sv
package cts_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE       = 3'd0,
    ST_RUNNING    = 3'd1,
    ST_SQUASHING  = 3'd2,
    ST_TRAP_PEND  = 3'd3,
    ST_FETCH_TRAP = 3'd4
  } thr_state_e;

  typedef enum logic [1:0] {
    POL_GREEDY = 2'd0,
    POL_ROTATE = 2'd1,
    POL_OLDEST = 2'd2,
    POL_RSVD   = 2'd3
  } pol_e;
endpackage

// File: rtl/cts_rr_order.sv
module cts_rr_order #(
  parameter int NT    = 4,
  parameter int TID_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NT-1:0]    elig_i,
  input  logic             advance_i,
  output logic             hit_o,
  output logic [TID_W-1:0] tid_o
);
  logic [TID_W-1:0] order_q [NT];
  logic [TID_W-1:0] order_d [NT];
  logic [TID_W-1:0] pos;

  always_comb begin
    hit_o = 1'b0;
    pos   = '0;
    tid_o = '0;
    for (int i = 0; i < NT; i++) begin
      if (!hit_o && elig_i[order_q[i]]) begin
        hit_o = 1'b1;
        pos   = TID_W'(i);
        tid_o = order_q[i];
      end
    end
  end

  // move-to-back of the picked position
  always_comb begin
    for (int i = 0; i < NT; i++) begin
      if (i < int'(pos))   order_d[i] = order_q[i];
      else if (i == NT-1)  order_d[i] = order_q[pos];
      else                 order_d[i] = order_q[(i+1) % NT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NT; i++) order_q[i] <= TID_W'(i);
    end else if (advance_i && hit_o) begin
      for (int i = 0; i < NT; i++) order_q[i] <= order_d[i];
    end
  end

  logic [NT*TID_W-1:0] order_flat;
  logic [NT-1:0]       seen;
  always_comb begin
    seen = '0;
    for (int i = 0; i < NT; i++) begin
      order_flat[i*TID_W +: TID_W] = order_q[i];
      seen[order_q[i]] = 1'b1;
    end
  end

  // R3
  order_perm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(seen) == NT);
  // R3
  moved_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && hit_o) |=> order_q[NT-1] == $past(tid_o));
  // R4
  order_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(advance_i && hit_o) |=> $stable(order_flat));
endmodule

// File: rtl/cts_oldest_pick.sv
module cts_oldest_pick #(
  parameter int NT    = 4,
  parameter int TID_W = 2,
  parameter int SEQ_W = 16
) (
  input  logic [NT-1:0]       elig_i,
  input  logic [NT*SEQ_W-1:0] seq_i,
  output logic                hit_o,
  output logic [TID_W-1:0]    tid_o
);
  logic [SEQ_W-1:0] best_seq;

  always_comb begin
    hit_o    = 1'b0;
    tid_o    = '0;
    best_seq = '0;
    for (int t = 0; t < NT; t++) begin
      // strict compare keeps the lowest index on ties
      if (elig_i[t] && (!hit_o || seq_i[t*SEQ_W +: SEQ_W] < best_seq)) begin
        hit_o    = 1'b1;
        tid_o    = TID_W'(t);
        best_seq = seq_i[t*SEQ_W +: SEQ_W];
      end
    end
  end
endmodule

// File: rtl/commit_thread_sel.sv
module commit_thread_sel
  import cts_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W       = 16,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [1:0]                     policy_i,
  input  logic [STATE_W*NUM_THREADS-1:0] state_i,
  input  logic [NUM_THREADS-1:0]         rob_empty_i,
  input  logic [NUM_THREADS-1:0]         head_ready_i,
  input  logic [SEQ_W*NUM_THREADS-1:0]   head_seq_i,
  input  logic                           consume_i,
  output logic                           valid_o,
  output logic [TID_W-1:0]               tid_o
);
  function automatic logic st_commit_ok(input logic [STATE_W-1:0] s);
    return s == ST_IDLE || s == ST_RUNNING;
  endfunction

  function automatic logic st_oldest_ok(input logic [STATE_W-1:0] s);
    return s == ST_IDLE || s == ST_RUNNING || s == ST_FETCH_TRAP;
  endfunction

  if (NUM_THREADS == 1) begin : g_single
    assign valid_o = st_oldest_ok(state_i[STATE_W-1:0]);
    assign tid_o   = '0;
  end else begin : g_multi
    logic [NUM_THREADS-1:0] rr_elig, old_elig;
    logic                   rr_hit, old_hit, rr_adv;
    logic [TID_W-1:0]       rr_tid, old_tid;

    always_comb begin
      for (int t = 0; t < NUM_THREADS; t++) begin
        rr_elig[t]  = st_commit_ok(state_i[t*STATE_W +: STATE_W]) && head_ready_i[t];
        old_elig[t] = st_oldest_ok(state_i[t*STATE_W +: STATE_W]) && head_ready_i[t]
                      && !rob_empty_i[t];
      end
    end

    assign rr_adv = consume_i && (pol_e'(policy_i) == POL_ROTATE);

    cts_rr_order #(.NT(NUM_THREADS), .TID_W(TID_W)) u_rr (
      .clk_i, .rst_ni, .elig_i(rr_elig), .advance_i(rr_adv),
      .hit_o(rr_hit), .tid_o(rr_tid)
    );

    cts_oldest_pick #(.NT(NUM_THREADS), .TID_W(TID_W), .SEQ_W(SEQ_W)) u_old (
      .elig_i(old_elig), .seq_i(head_seq_i), .hit_o(old_hit), .tid_o(old_tid)
    );

    always_comb begin
      valid_o = 1'b0;
      tid_o   = '0;
      unique case (pol_e'(policy_i))
        POL_ROTATE: begin valid_o = rr_hit;  tid_o = rr_tid;  end
        POL_GREEDY,
        POL_OLDEST: begin valid_o = old_hit; tid_o = old_tid; end
        default:    ;
      endcase
    end

    // R9
    rsvd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pol_e'(policy_i) == POL_RSVD) |-> !valid_o);
    // R5
    oldest_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && pol_e'(policy_i) != POL_ROTATE) |-> !rob_empty_i[tid_o]);
    // R2
    rr_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && pol_e'(policy_i) == POL_ROTATE) |->
        (head_ready_i[tid_o] && state_i[tid_o*STATE_W +: STATE_W] <= ST_RUNNING));
    // R8
    none_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_o |-> tid_o == '0);
  end
endmodule

// File: tb/commit_thread_sel_test.sv
module commit_thread_sel_test;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int SW = 16;

  logic clk = 0, rst_n = 0;
  logic [1:0]     pol = 2'd1;
  logic [3*NT-1:0] st = '0;
  logic [NT-1:0]  emp = '0, rdy = '0;
  logic [SW*NT-1:0] seq = '0;
  logic           cons = 0;
  logic           vld;
  logic [1:0]     tid;
  logic [2:0]     st1 = '0;
  logic           emp1 = 0, rdy1 = 0, vld1;
  logic [0:0]     tid1;

  int checks = 0, fails = 0;
  int rrq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  commit_thread_sel #(.NUM_THREADS(NT), .SEQ_W(SW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(pol), .state_i(st), .rob_empty_i(emp),
    .head_ready_i(rdy), .head_seq_i(seq), .consume_i(cons), .valid_o(vld), .tid_o(tid));

  commit_thread_sel #(.NUM_THREADS(1), .SEQ_W(SW)) uut1 (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(pol), .state_i(st1), .rob_empty_i(emp1),
    .head_ready_i(rdy1), .head_seq_i(seq[SW-1:0]), .consume_i(cons), .valid_o(vld1),
    .tid_o(tid1));

  function automatic int sget(int t); return int'(st[t*3 +: 3]); endfunction

  // behavioural reference: returns expected valid/tid and queue position
  task automatic model(output bit ev, output int et, output int ep);
    ev = 0; et = 0; ep = -1;
    if (pol == 2'd1) begin
      foreach (rrq[i]) begin
        int t = rrq[i];
        if (!ev && (sget(t) == 0 || sget(t) == 1) && rdy[t]) begin
          ev = 1; et = t; ep = i;
        end
      end
    end else if (pol != 2'd3) begin
      int best = -1;
      for (int t = 0; t < NT; t++) begin
        int s = sget(t);
        if (!emp[t] && rdy[t] && (s == 0 || s == 1 || s == 4))
          if (best < 0 || seq[t*SW +: SW] < seq[best*SW +: SW]) best = t;
      end
      if (best >= 0) begin ev = 1; et = best; end
    end
  endtask

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // compare after inputs settle, then advance model at the coming edge
  task automatic step(string req_in);
    bit ev; int et, ep; string req;
    #1;
    model(ev, et, ep);
    req = req_in;
    if (req == "") begin
      if (!ev)             req = (pol == 2'd3) ? "R9" : "R8";
      else if (pol == 2'd1) req = "R2";
      else if (pol == 2'd0) req = "R7";
      else                 req = "R5";
    end
    chk({req, " valid"}, int'(vld), int'(ev));
    chk({req, " tid"}, int'(tid), et);
    // R10 single-thread variant
    chk("R10 valid", int'(vld1), int'(st1 == 3'd0 || st1 == 3'd1 || st1 == 3'd4));
    chk("R10 tid", int'(tid1), 0);
    if (cons && ev && pol == 2'd1) begin
      rrq.delete(ep);
      rrq.push_back(et);
    end
    @(negedge clk);
  endtask

  task automatic set_all(int s, bit r, bit e);
    for (int t = 0; t < NT; t++) begin
      st[t*3 +: 3] = 3'(s); rdy[t] = r; emp[t] = e;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: got hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rrq = {0, 1, 2, 3};
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8 reset state: nothing ready
    pol = 2'd1; set_all(1, 0, 1);
    step("R8");
    // R1 ascending order after reset, R3 rotation
    set_all(1, 1, 0); cons = 1;
    for (int i = 0; i < 6; i++) step("R1");
    // R4 no consume keeps order
    cons = 0;
    for (int i = 0; i < 3; i++) step("R4");
    // R4 consume under other policy keeps order
    cons = 1; pol = 2'd2;
    for (int i = 0; i < 3; i++) step("R4");
    pol = 2'd1; step("R4");
    // R2 empty ignored, squashing skipped
    emp = '1; st[3 +: 3] = 3'd2; st[6 +: 3] = 3'd4;
    for (int i = 0; i < 4; i++) step("R2");
    // R6 ties
    pol = 2'd2; cons = 0; set_all(0, 1, 0);
    for (int t = 0; t < NT; t++) seq[t*SW +: SW] = 16'd5;
    step("R6");
    rdy[0] = 0; step("R6");
    pol = 2'd0; step("R6");
    // R5 fetch-fault pending thread eligible and oldest
    set_all(1, 1, 0); st[9 +: 3] = 3'd4; seq[3*SW +: SW] = 16'd1;
    step("R5");
    // R9 reserved
    pol = 2'd3; step("R9");
    // random
    for (int n = 0; n < 3000; n++) begin
      pol  = 2'($urandom_range(0, 3));
      cons = 1'($urandom_range(0, 1));
      for (int t = 0; t < NT; t++) begin
        st[t*3 +: 3]   = 3'($urandom_range(0, 4));
        rdy[t]         = ($urandom_range(0, 3) != 0);
        emp[t]         = ($urandom_range(0, 4) == 0);
        seq[t*SW +: SW] = 16'($urandom_range(0, 7));
      end
      st1  = 3'($urandom_range(0, 4));
      rdy1 = 1'($urandom_range(0, 1));
      emp1 = 1'($urandom_range(0, 1));
      step("");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule